// File: doc/BRIEF.md
# Hypotenuse Approximation Unit

The block estimates the length of the hypotenuse of a right triangle whose two legs are unsigned integers. It needs no multiplier and no square root. It takes the larger leg x and the smaller leg y and returns max(x, x - x/8 + y/2). Both divisions are logical right shifts that truncate.

The work is split into two parts:

- A control part. It is a state machine that issues load enables and function selects.
- A data part. It holds four working registers and one shared comparator, one shared adder/subtractor and two fixed right shifters. It returns an overflow flag to the control part.

A computation starts with a START pulse while the unit is idle. It runs a fixed sequence of one register transfer per cycle. It finishes in one of two ways:

- A one-cycle DONE pulse, with the result on C.
- A one-cycle ERR pulse, when the sum step overflows the register width.

The surrounding logic must hold A and B steady from START until the DONE or ERR pulse.

Top module: `hyp_approx`

## Requirements
- R1: While reset is active, and after reset is released, `done` and `err` are low and `c_out` is zero until a computation completes.
- R2: While idle and with `start` low, no `done` or `err` pulse appears, whatever `a_in` and `b_in` do.
- R3: With A and B held, and x = max(A,B), y = min(A,B), s = x - floor(x/8) + floor(y/2), a run with s <= 2^W-1 delivers `c_out` = max(x, s). Here W is 8 bits by default.
- R4: On such a run, `done` is high for exactly one cycle: the eighth cycle after the rising clock edge that samples `start` high in idle.
- R5: If s exceeds 2^W-1, `err` is high for exactly one cycle, the seventh cycle after the sampling edge, and `done` does not pulse for that run.
- R6: A run that ends in `err` leaves `c_out` at the result of the last successful run.
- R7: `start` asserted while a computation is in progress is ignored. The running computation keeps its timing and result.
- R8: A new `start` is accepted in the first cycle after the `done` or `err` pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a computation when idle |
| a_in | input | W | First leg, unsigned |
| b_in | input | W | Second leg, unsigned |
| c_out | output | W | Approximate hypotenuse from the last successful run |
| done | output | 1 | One-cycle pulse: result valid |
| err | output | 1 | One-cycle pulse: sum overflowed |

## Verification
Counted from the rising edge that samples `start`, the error pulse is due seven edges later. The done pulse and the new `c_out` value are due eight edges later. The unit accepts a fresh start on the ninth.

The bench drives inputs on falling edges and samples once per falling edge after each of the eight following rising edges. For every run it records at which sample `done` and `err` were high. It then compares those positions, and `c_out` at the done sample, against values computed arithmetically from the leg pair. The leg pairs are swept over a dense grid. Runs are issued back to back, and some runs carry a second start pulse in mid-run.

// File: rtl/hyp_pkg.sv
package hyp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MAX,
    ST_MIN,
    ST_HALF,
    ST_EIGHTH,
    ST_SUB,
    ST_ADD,
    ST_CMP,
    ST_DONE,
    ST_ERR
  } hyp_state_e;

  typedef struct packed {
    logic ld_x;      // Rx <= comparator max
    logic ld_y;      // Ry load
    logic y_half;    // Ry source: 1 = Ry >> 1, 0 = comparator min
    logic ld_t;      // Rt load
    logic t_alu;     // Rt source: 1 = adder/subtractor, 0 = Rx >> 3
    logic alu_sub;   // 1 = Rx - Rt, 0 = Ry + Rt
    logic ld_c;      // Rc <= comparator max
    logic cmp_regs;  // comparator operands: 1 = (Rx, Rt), 0 = (A, B)
  } hyp_ctl_t;

endpackage

// File: rtl/hyp_shr.sv
module hyp_shr #(
  parameter int W  = 8,
  parameter int SH = 1
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  assign q = d >> SH;
endmodule

// File: rtl/hyp_cmp.sv
module hyp_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] r,
  output logic [W-1:0] mx,
  output logic [W-1:0] mn
);
  logic p_ge;
  assign p_ge = (p >= r);
  assign mx   = p_ge ? p : r;
  assign mn   = p_ge ? r : p;
endmodule

// File: rtl/hyp_addsub.sv
module hyp_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  logic [W:0] wide;
  always_comb begin
    if (sub) wide = {1'b0, opa} - {1'b0, opb};
    else     wide = {1'b0, opa} + {1'b0, opb};
  end
  assign res = wide[W-1:0];
  assign ovf = wide[W] & ~sub;
endmodule

// File: rtl/hyp_dp.sv
module hyp_dp
  import hyp_pkg::*;
#(
  parameter int W        = 8,
  parameter int HALF_SH  = 1,
  parameter int EIGHT_SH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  hyp_ctl_t     ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] c,
  output logic         ovf
);
  logic [W-1:0] rx_q, ry_q, rt_q, rc_q;
  logic [W-1:0] cmp_p, cmp_r, cmp_mx, cmp_mn;
  logic [W-1:0] ry_sh, rx_sh;
  logic [W-1:0] alu_a, alu_res;

  assign cmp_p = ctl.cmp_regs ? rx_q : a;
  assign cmp_r = ctl.cmp_regs ? rt_q : b;

  hyp_cmp #(.W(W)) u_cmp (
    .p(cmp_p), .r(cmp_r), .mx(cmp_mx), .mn(cmp_mn)
  );

  hyp_shr #(.W(W), .SH(HALF_SH))  u_shr_y (.d(ry_q), .q(ry_sh));
  hyp_shr #(.W(W), .SH(EIGHT_SH)) u_shr_x (.d(rx_q), .q(rx_sh));

  assign alu_a = ctl.alu_sub ? rx_q : ry_q;

  hyp_addsub #(.W(W)) u_alu (
    .opa(alu_a), .opb(rt_q), .sub(ctl.alu_sub), .res(alu_res), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      ry_q <= '0;
      rt_q <= '0;
      rc_q <= '0;
    end else begin
      if (ctl.ld_x) rx_q <= cmp_mx;
      if (ctl.ld_y) ry_q <= ctl.y_half ? ry_sh : cmp_mn;
      if (ctl.ld_t) rt_q <= ctl.t_alu ? alu_res : rx_sh;
      if (ctl.ld_c) rc_q <= cmp_mx;
    end
  end

  assign c = rc_q;
endmodule

// File: rtl/hyp_ctrl.sv
module hyp_ctrl
  import hyp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     ovf,
  output hyp_ctl_t ctl,
  output logic     done,
  output logic     err
);
  hyp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_MAX;
      ST_MAX:    begin ctl.ld_x = 1'b1; state_d = ST_MIN; end
      ST_MIN:    begin ctl.ld_y = 1'b1; state_d = ST_HALF; end
      ST_HALF:   begin ctl.ld_y = 1'b1; ctl.y_half = 1'b1; state_d = ST_EIGHTH; end
      ST_EIGHTH: begin ctl.ld_t = 1'b1; state_d = ST_SUB; end
      ST_SUB:    begin
        ctl.ld_t = 1'b1; ctl.t_alu = 1'b1; ctl.alu_sub = 1'b1;
        state_d  = ST_ADD;
      end
      ST_ADD:    begin
        ctl.ld_t = 1'b1; ctl.t_alu = 1'b1;
        state_d  = ovf ? ST_ERR : ST_CMP;
      end
      ST_CMP:    begin ctl.ld_c = 1'b1; ctl.cmp_regs = 1'b1; state_d = ST_DONE; end
      ST_DONE:   state_d = ST_IDLE;
      ST_ERR:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign done = (state_q == ST_DONE);
  assign err  = (state_q == ST_ERR);
endmodule

// File: rtl/hyp_approx.sv
module hyp_approx
  import hyp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] c_out,
  output logic         done,
  output logic         err
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  hyp_ctl_t   ctl;
  logic       ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  hyp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .start(start), .ovf(ovf),
    .ctl(ctl), .done(done), .err(err)
  );

  hyp_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_q_n), .ctl(ctl), .a(a_in), .b(b_in),
    .c(c_out), .ovf(ovf)
  );
endmodule

// File: rtl/hyp_approx_chk.sv
module hyp_approx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] c_out,
  input logic         done,
  input logic         err
);
  // R3
  result_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (c_out >= a_in && c_out >= b_in));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 8));

  // R5
  err_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start, 7));

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(c_out));
endmodule

bind hyp_approx hyp_approx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .start(start), .a_in(a_in), .b_in(b_in),
  .c_out(c_out), .done(done), .err(err)
);

// File: tb/hyp_approx_test.sv
module hyp_approx_test;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] c_out;
  logic         done, err;

  int n_checks = 0;
  int n_fail   = 0;
  int c_hold   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hyp_approx #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .c_out(c_out), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the 8th rising edge.
  task automatic run_vec(input int a, input int b, input bit glitch, input string tag);
    int x, y, s, expc;
    int done_cnt, err_cnt, done_at, err_at, c_at_done;
    bit over;
    x = (a > b) ? a : b;
    y = (a > b) ? b : a;
    s = x - (x >> 3) + (y >> 1);
    over = (s > MAXV);
    expc = (s > x) ? s : x;
    done_cnt = 0; err_cnt = 0; done_at = 0; err_at = 0; c_at_done = 0;
    a_in  = a[W-1:0];
    b_in  = b[W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (done) begin done_cnt++; done_at = i; c_at_done = int'(c_out); end
      if (err)  begin err_cnt++;  err_at  = i; end
      if (glitch && i == 2) begin
        start = 1'b1;                 // R7: ignored while busy
        a_in  = ~a[W-1:0];
      end
      if (glitch && i == 3) begin
        start = 1'b0;
        a_in  = a[W-1:0];
      end
    end
    if (over) begin
      check(err_cnt == 1 && err_at == 6, {tag, " R5 err cycle"}, err_at, 6);
      check(done_cnt == 0, {tag, " R5 no done"}, done_cnt, 0);
      check(int'(c_out) == c_hold, {tag, " R6 c held"}, int'(c_out), c_hold);
    end else begin
      check(done_cnt == 1 && done_at == 7, {tag, " R4 done cycle"}, done_at, 7);
      check(err_cnt == 0, {tag, " R4 no err"}, err_cnt, 0);
      check(c_at_done == expc, {tag, " R3 result"}, c_at_done, expc);
      c_hold = expc;
    end
  endtask

  initial begin
    int idle_hits;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && err == 1'b0, "R1 flags in reset", int'(done) + int'(err), 0);
    check(c_out == '0, "R1 c in reset", int'(c_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && err == 1'b0 && c_out == '0, "R1 after release",
          int'(c_out), 0);

    idle_hits = 0;
    for (int i = 0; i < 20; i++) begin
      a_in = W'(i * 37);
      b_in = W'(i * 91);
      @(negedge clk);
      if (done || err) idle_hits++;
    end
    check(idle_hits == 0, "R2 idle no pulse", idle_hits, 0);
    check(c_out == '0, "R2 idle c unchanged", int'(c_out), 0);

    run_vec(0, 0, 1'b0, "corner 0,0");
    run_vec(8, 2, 1'b0, "corner 8,2");
    run_vec(MAXV, 0, 1'b0, "corner max,0");
    run_vec(MAXV, MAXV, 1'b0, "corner max,max");
    run_vec(3, 200, 1'b0, "R8 back-to-back after err");
    run_vec(100, 90, 1'b1, "R7 glitch ok");
    run_vec(250, 240, 1'b1, "R7 glitch ovf");
    run_vec(1, 1, 1'b0, "R8 after err");

    for (int a = 0; a <= MAXV; a += 5) begin
      for (int b = 0; b <= MAXV; b += 3) begin
        run_vec(a, b, 1'b0, "sweep");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule